// File: doc/BRIEF.md
# Accumulator Pack Unit

This unit turns two wide signed accumulators into a pair of 16-bit lanes and returns them together as one 32-bit word. It is meant for the drain step after a multiply-accumulate run. There the wide sum is rescaled by a fixed-point shift and then narrowed to the lane width.

A mode input picks how each accumulator is narrowed. Wrap keeps the low bits. Round adds half of the last kept bit and shifts right. Three saturating modes shift arithmetically and then clamp: rounded to the signed range, truncated to the signed range, or rounded to the unsigned range. The shift amount comes from a separate scalar operand. The same mode and shift apply to both lanes of one issue.

A new pair can be issued every cycle. Each packed result appears a fixed number of cycles after its issue, together with a valid flag.

Top module: `acc_pack_unit`

## Requirements
- R1: Mode 0 (wrap) returns bits [15:0] of each accumulator, with no shift and no clamp. For example, 0x8001 gives 0x8001 and 0x10000 gives 0x0000.
- R2: Mode 1 (round) adds the bias 2^(sh-1) to the sign-extended accumulator, shifts it arithmetically right by sh, and returns bits [15:0] of the result with no clamp.
- R3: Mode 2 (rounded signed saturate) rounds and shifts as in R2. It then returns 0x7FFF when the result exceeds 32767 and 0x8000 when it is below -32768. Otherwise it returns bits [15:0] of the result.
- R4: Mode 3 (truncating signed saturate) shifts arithmetically right by sh without any bias, then clamps as in R3.
- R5: Mode 4 (rounded unsigned saturate) rounds and shifts as in R2. A negative result gives 0x0000, a result above 65535 gives 0xFFFF, and any other result passes its bits [15:0].
- R6: The shift amount sh is bits [4:0] of the scalar shift input. All higher bits of that input have no effect.
- R7: When sh = 0, no bias is added in any mode, so rounding modes return the unshifted value.
- R8: The result of the first accumulator occupies bits [15:0] of the output word, and the result of the second occupies bits [31:16].
- R9: The valid flag rises exactly 12 clock cycles after the cycle in which the issue strobe is high. It lasts one cycle per issue, so back-to-back issues give back-to-back results.
- R10: While reset is high and in the cycle after it, the valid flag is low.
- R11: Mode codes 5, 6 and 7 behave as wrap (mode 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Issue strobe for one accumulator pair |
| mode_i | input | 3 | Narrowing mode select |
| shamt_i | input | 32 | Scalar shift operand; only bits [4:0] are used |
| acc_lo_i | input | 48 | First accumulator, two's complement |
| acc_hi_i | input | 48 | Second accumulator, two's complement |
| word_o | output | 32 | Packed pair of 16-bit results |
| word_valid_o | output | 1 | High in the cycle word_o carries a result |

## Verification
The bench builds the unit with its default parameters: 48-bit accumulators, 16-bit lanes, a 5-bit shift field and a 12-cycle latency. With a 48-bit accumulator and shifts of up to 31, every clamp boundary is reachable: positive and negative signed overflow, unsigned overflow, and negative-to-zero clamping. The rounding bias also reaches its largest value, 2^30. Directed issues hit each mode at the exact overflow edges, sh = 0, and shift operands with high bits set. A long run of back-to-back and gapped random issues then checks the 12-cycle spacing of every result against a queue-based model.

// File: rtl/apu_pkg.sv
package apu_pkg;
  typedef enum logic [2:0] {
    PK_WRAP = 3'd0,
    PK_RND  = 3'd1,
    PK_RSAT = 3'd2,
    PK_TSAT = 3'd3,
    PK_USAT = 3'd4
  } pk_mode_e;
endpackage

// File: rtl/apu_lane.sv
module apu_lane
  import apu_pkg::*;
#(
  parameter int ACC_W  = 48,
  parameter int LANE_W = 16,
  parameter int SH_W   = 5
) (
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [SH_W-1:0]   sh_i,
  input  logic [2:0]        mode_i,
  output logic [LANE_W-1:0] lane_o
);
  localparam int EXT_W = ACC_W + 1;

  logic signed [EXT_W-1:0] ext_val;
  logic signed [EXT_W-1:0] bias;
  logic signed [EXT_W-1:0] sum;
  logic signed [EXT_W-1:0] shifted;
  logic                    use_bias;
  logic                    s_fits;
  logic                    u_neg;
  logic                    u_over;

  always_comb begin
    ext_val  = {acc_i[ACC_W-1], acc_i};
    use_bias = (mode_i == PK_RND) || (mode_i == PK_RSAT) || (mode_i == PK_USAT);
    if (sh_i == '0) bias = '0;
    else            bias = EXT_W'(1) << (sh_i - 1'b1);
    sum      = ext_val + (use_bias ? bias : '0);
    shifted  = sum >>> sh_i;
    s_fits   = (&shifted[EXT_W-1:LANE_W-1]) | ~(|shifted[EXT_W-1:LANE_W-1]);
    u_neg    = shifted[EXT_W-1];
    u_over   = |shifted[EXT_W-2:LANE_W];
  end

  always_comb begin
    case (mode_i)
      PK_RND: lane_o = shifted[LANE_W-1:0];
      PK_RSAT, PK_TSAT: begin
        if (s_fits)               lane_o = shifted[LANE_W-1:0];
        else if (shifted[EXT_W-1]) lane_o = {1'b1, {(LANE_W-1){1'b0}}};
        else                      lane_o = {1'b0, {(LANE_W-1){1'b1}}};
      end
      PK_USAT: begin
        if (u_neg)       lane_o = '0;
        else if (u_over) lane_o = '1;
        else             lane_o = shifted[LANE_W-1:0];
      end
      default: lane_o = acc_i[LANE_W-1:0];
    endcase
  end
endmodule

// File: rtl/apu_delay.sv
module apu_delay #(
  parameter int W     = 32,
  parameter int DEPTH = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         v_i,
  input  logic [W-1:0] d_i,
  output logic         v_o,
  output logic [W-1:0] d_o
);
  logic [DEPTH-1:0] v_sr;
  logic [W-1:0]     d_sr [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) v_sr <= '0;
    else     v_sr <= {v_sr[DEPTH-2:0], v_i};
  end

  always_ff @(posedge clk) d_sr[0] <= d_i;

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk) d_sr[g] <= d_sr[g-1];
  end

  assign v_o = v_sr[DEPTH-1];
  assign d_o = d_sr[DEPTH-1];
endmodule

// File: rtl/acc_pack_unit.sv
module acc_pack_unit
  import apu_pkg::*;
#(
  parameter int ACC_W   = 48,
  parameter int LANE_W  = 16,
  parameter int SH_W    = 5,
  parameter int SHIN_W  = 32,
  parameter int LATENCY = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                issue_i,
  input  logic [2:0]          mode_i,
  input  logic [SHIN_W-1:0]   shamt_i,
  input  logic [ACC_W-1:0]    acc_lo_i,
  input  logic [ACC_W-1:0]    acc_hi_i,
  output logic [2*LANE_W-1:0] word_o,
  output logic                word_valid_o
);
  localparam int NLANE  = 2;
  localparam int WORD_W = NLANE * LANE_W;
  localparam int TAIL   = LATENCY - 1;

  logic [SH_W-1:0]   sh;
  logic              unused_shamt_hi;
  logic [ACC_W-1:0]  acc_in [NLANE];
  logic [WORD_W-1:0] packed_w;
  logic              s1_v;
  logic [WORD_W-1:0] s1_w;

  assign sh              = shamt_i[SH_W-1:0];
  assign unused_shamt_hi = ^shamt_i[SHIN_W-1:SH_W];
  assign acc_in[0]       = acc_lo_i;
  assign acc_in[1]       = acc_hi_i;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    apu_lane #(.ACC_W(ACC_W), .LANE_W(LANE_W), .SH_W(SH_W)) u_lane (
      .acc_i  (acc_in[l]),
      .sh_i   (sh),
      .mode_i (mode_i),
      .lane_o (packed_w[l*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) s1_v <= 1'b0;
    else     s1_v <= issue_i;
    s1_w <= packed_w;
  end

  apu_delay #(.W(WORD_W), .DEPTH(TAIL)) u_tail (
    .clk (clk),
    .rst (rst),
    .v_i (s1_v),
    .d_i (s1_w),
    .v_o (word_valid_o),
    .d_o (word_o)
  );
endmodule

// File: rtl/acc_pack_unit_chk.sv
module acc_pack_unit_chk #(
  parameter int ACC_W   = 48,
  parameter int LANE_W  = 16,
  parameter int LATENCY = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                issue_i,
  input logic [2:0]          mode_i,
  input logic [4:0]          sh_i,
  input logic [ACC_W-1:0]    acc_lo_i,
  input logic [ACC_W-1:0]    acc_hi_i,
  input logic [2*LANE_W-1:0] word_o,
  input logic                word_valid_o
);
  logic [LATENCY-1:0] iss_sr;
  logic [2:0]         md_sr [LATENCY];
  logic [4:0]         sh_sr [LATENCY];
  logic [LANE_W:0]    lo_sr [LATENCY];
  logic [LANE_W:0]    hi_sr [LATENCY];

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_sr <= '0;
      for (int i = 0; i < LATENCY; i++) begin
        md_sr[i] <= '0; sh_sr[i] <= '0; lo_sr[i] <= '0; hi_sr[i] <= '0;
      end
    end else begin
      iss_sr   <= {iss_sr[LATENCY-2:0], issue_i};
      md_sr[0] <= mode_i;
      sh_sr[0] <= sh_i;
      lo_sr[0] <= {acc_lo_i[ACC_W-1], acc_lo_i[LANE_W-1:0]};
      hi_sr[0] <= {acc_hi_i[ACC_W-1], acc_hi_i[LANE_W-1:0]};
      for (int i = 1; i < LATENCY; i++) begin
        md_sr[i] <= md_sr[i-1]; sh_sr[i] <= sh_sr[i-1];
        lo_sr[i] <= lo_sr[i-1]; hi_sr[i] <= hi_sr[i-1];
      end
    end
  end

  wire [2:0]      d_md = md_sr[LATENCY-1];
  wire [4:0]      d_sh = sh_sr[LATENCY-1];
  wire [LANE_W:0] d_lo = lo_sr[LATENCY-1];
  wire [LANE_W:0] d_hi = hi_sr[LATENCY-1];

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    word_valid_o == iss_sr[LATENCY-1]);  // R9

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> !word_valid_o);  // R10

  AST_WRAP_LOW: assert property (@(posedge clk) disable iff (rst)
    (word_valid_o && d_md == 3'd0) |-> word_o == {d_hi[LANE_W-1:0], d_lo[LANE_W-1:0]});  // R1

  AST_ZERO_SHIFT_ROUND: assert property (@(posedge clk) disable iff (rst)
    (word_valid_o && d_md == 3'd1 && d_sh == 5'd0) |-> word_o == {d_hi[LANE_W-1:0], d_lo[LANE_W-1:0]});  // R7

  AST_NEG_STAYS_NONPOS: assert property (@(posedge clk) disable iff (rst)
    (word_valid_o && d_md == 3'd2 && d_lo[LANE_W]) |-> (word_o[LANE_W-1:0] == '0 || word_o[LANE_W-1]));  // R3
endmodule

bind acc_pack_unit acc_pack_unit_chk #(
  .ACC_W(ACC_W), .LANE_W(LANE_W), .LATENCY(LATENCY)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .issue_i      (issue_i),
  .mode_i       (mode_i),
  .sh_i         (shamt_i[4:0]),
  .acc_lo_i     (acc_lo_i),
  .acc_hi_i     (acc_hi_i),
  .word_o       (word_o),
  .word_valid_o (word_valid_o)
);

// File: tb/acc_pack_unit_test.sv
module acc_pack_unit_test;
  localparam int LAT = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [31:0] shamt_i = '0;
  logic [47:0] acc_lo_i = '0;
  logic [47:0] acc_hi_i = '0;
  logic [31:0] word_o;
  logic        word_valid_o;
  string       cur_tag = "R9";

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  logic        q_v [$];
  logic [31:0] q_w [$];
  string       q_t [$];

  always #5 clk = ~clk;

  acc_pack_unit uut (
    .clk(clk), .rst(rst), .issue_i(issue_i), .mode_i(mode_i), .shamt_i(shamt_i),
    .acc_lo_i(acc_lo_i), .acc_hi_i(acc_hi_i), .word_o(word_o), .word_valid_o(word_valid_o)
  );

  function automatic logic [15:0] ref_lane(logic [47:0] acc, int sh, int mode);
    longint a, b, s;
    a = longint'({{16{acc[47]}}, acc});
    b = (sh == 0) ? 0 : (longint'(1) <<< (sh - 1));
    case (mode)
      1: begin s = (a + b) >>> sh; return s[15:0]; end
      2, 3: begin
        s = (mode == 3) ? (a >>> sh) : ((a + b) >>> sh);
        if (s > 32767) return 16'h7FFF;
        if (s < -32768) return 16'h8000;
        return s[15:0];
      end
      4: begin
        s = (a + b) >>> sh;
        if (s < 0) return 16'h0000;
        if (s > 65535) return 16'hFFFF;
        return s[15:0];
      end
      default: return acc[15:0];
    endcase
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      q_v.push_back(1'b0); q_w.push_back('0); q_t.push_back("R10");
    end else begin
      q_v.push_back(issue_i);
      q_w.push_back({ref_lane(acc_hi_i, int'(shamt_i & 32'd31), int'(mode_i)),
                     ref_lane(acc_lo_i, int'(shamt_i & 32'd31), int'(mode_i))});
      q_t.push_back(issue_i ? cur_tag : "R9");
    end
  end

  always @(negedge clk) begin
    if (q_v.size() == LAT) begin
      logic ev; logic [31:0] ew; string et;
      ev = q_v.pop_front(); ew = q_w.pop_front(); et = q_t.pop_front();
      total++;
      if (word_valid_o !== ev) begin
        bad++;
        $display("FAIL %s valid: actual=%b expected=%b", ev ? "R9" : et, word_valid_o, ev);
      end
      if (ev) begin
        total++;
        if (word_o !== ew) begin
          bad++;
          $display("FAIL %s word: actual=%h expected=%h", et, word_o, ew);
        end
      end
    end
  end

  task automatic put(input logic [2:0] m, input logic [31:0] s,
                     input logic [47:0] lo, input logic [47:0] hi, input string t);
    @(negedge clk);
    issue_i = 1'b1; mode_i = m; shamt_i = s; acc_lo_i = lo; acc_hi_i = hi; cur_tag = t;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      issue_i = 1'b0; cur_tag = "R9";
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (word_valid_o !== 1'b0) begin
      bad++;
      $display("FAIL R10 reset valid: actual=%b expected=0", word_valid_o);
    end
    rst = 1'b0;
    // R1 wrap examples
    put(3'd0, 32'd7, 48'h0000_0000_8001, 48'h0000_0001_0000, "R1");
    // R2 round with bias: (24+8)>>4=2, (23+8)>>4=1
    put(3'd1, 32'd4, 48'h18, 48'h17, "R2");
    put(3'd1, 32'd31, 48'h7FFF_FFFF_FFFF, 48'h8000_0000_0000, "R2");
    // R3 rounded signed saturate: overflow both ways, then fitting values
    put(3'd2, 32'd8, 48'h0000_7FFF_FF80, 48'hFFFF_8000_0000, "R3");
    put(3'd2, 32'd8, 48'h0000_007F_FF7F, 48'hFFFF_FF80_0000, "R3");
    put(3'd2, 32'd8, 48'h0000_007F_FF80, 48'hFFFF_FF7F_FF7F, "R3");
    // R4 truncating saturate: 0x1F>>4=1, -17>>>4=-2
    put(3'd3, 32'd4, 48'h1F, 48'hFFFF_FFFF_FFEF, "R4");
    put(3'd3, 32'd0, 48'h0000_0000_8000, 48'hFFFF_FFFF_7FFF, "R4");
    // R5 unsigned saturate
    put(3'd4, 32'd0, 48'hFFFF_FFFF_FFFB, 48'h0000_0001_2345, "R5");
    put(3'd4, 32'd1, 48'h0000_0001_7DDE, 48'h0000_0001_FFFF, "R5");
    // R6 upper shift bits ignored: 0x21 acts as sh=1
    put(3'd1, 32'hFFFF_FFE1, 48'h3, 48'h5, "R6");
    // R7 sh=0: no bias in round modes
    put(3'd1, 32'd0, 48'h0000_0001_2345, 48'hFFFF_FFFF_FFFF, "R7");
    put(3'd2, 32'd0, 48'h0000_0000_7FFF, 48'hFFFF_FFFF_8000, "R7");
    // R8 lane placement
    put(3'd0, 32'd0, 48'h0000_0000_1111, 48'h0000_0000_2222, "R8");
    // R11 reserved codes behave as wrap
    put(3'd5, 32'd3, 48'h0000_0001_ABCD, 48'h0000_0000_8001, "R11");
    put(3'd7, 32'd9, 48'hFFFF_0000_4321, 48'h1234_5678_9ABC, "R11");
    idle(3);
    // R9 gapped and back-to-back random traffic
    for (int k = 0; k < 400; k++) begin
      logic [47:0] lo, hi;
      lo = {$urandom(), $urandom()};
      hi = {$urandom(), $urandom()};
      if (k % 3 == 0) begin
        lo = {{28{lo[19]}}, lo[19:0]};
        hi = {{28{hi[23]}}, hi[23:0]};
      end
      if (k % 5 == 4) idle(1 + (k % 4));
      put(3'($urandom_range(0, 7)), $urandom(), lo, hi, "R9");
    end
    idle(LAT + 4);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule